// File: doc/BRIEF.md
# Partial-Beat Stream Depacketizer

This block sits on a transmit path. It takes a packetized byte stream and turns it into a continuous stream with no gaps. Each input beat carries data, a per-lane keep mask and an end-of-packet marker. Every beat of a packet is full except possibly the final one. The block drops the unused lanes of that final beat and starts the next packet in the very next byte position. The output carries data only, with a valid/ready handshake and no framing.

Leftover bytes sit in a residual store two bus widths deep. A beat is offered downstream only once a whole bus width of bytes has gathered. A flush request pushes out any remaining bytes as one last beat padded with zeros. A keep mask that breaks the rules is treated as fully valid, and an error pulse reports it.

Top module: `byte_packer`

## Requirements
- R1: After reset, m_valid and keep_err are low, and s_ready is high while no flush is pending.
- R2: Full beats leave in the order they arrive. A beat accepted at a clock edge is visible on m_data from that edge on, provided the store held no partial bytes.
- R3: Only the valid bytes of a final beat are kept. The first byte of the next packet follows the last kept byte directly. Byte 0 of m_data (bits 7:0) is always the oldest byte.
- R4: s_keep bit i qualifies byte lane i (bits 8i+7:8i). On a beat with s_last high, a valid mask is nonzero and made of ones from bit 0 upward, and its count of ones is the number of bytes kept.
- R5: A final beat whose mask is zero or not contiguous from bit 0, or a non-final beat whose mask is not all ones, is taken as all bytes valid. keep_err is then high for exactly the cycle after that beat is accepted.
- R6: While m_valid is high and m_ready is low, m_valid stays high and m_data holds its value.
- R7: The store never holds more than two bus widths of bytes. s_ready is low whenever it holds more than one bus width and m_ready is low.
- R8: A flush pulse drains the store. Remaining full beats go first, then the leftover bytes go out as one beat with the unused high lanes zero. s_ready stays low until the store is empty.
- R9: With no flush pending, m_valid stays low while fewer than one bus width of bytes is held.
- R10: A run of full beats with m_ready held high is accepted on every cycle and leaves one beat per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_data | input | 8*BYTES | Input data, lane 0 in the low byte |
| s_keep | input | BYTES | Per-lane byte qualifier |
| s_last | input | 1 | Final beat of a packet |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the output beat |
| m_data | output | 8*BYTES | Packed output data |
| flush | input | 1 | One-cycle request to drain the residual bytes |
| keep_err | output | 1 | Pulse for a keep mask that breaks the rules |

## Verification
The bench uses the default width of four byte lanes. At this width every residual count from one to three bytes can be reached with short packets, and so can every kind of illegal mask: gapped, zero, high-lane-only, and a non-final beat that is not full. A four-lane bus also lets two stalled beats fill the two-width store. The bench can then show input back-pressure and a held output with only a few beats. Flush is tested with a single byte left over and with two bytes left over.

// File: rtl/byte_packer.sv
module byte_packer #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [8*BYTES-1:0] s_data,
  input  logic [BYTES-1:0]   s_keep,
  input  logic               s_last,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [8*BYTES-1:0] m_data,
  input  logic               flush,
  output logic               keep_err
);
  localparam int W   = 8 * BYTES;
  localparam int CAP = 2 * BYTES;
  localparam int CW  = $clog2(CAP + 1);
  localparam logic [CW-1:0] FULLC = CW'(BYTES);

  logic [2*W-1:0] acc;
  logic [CW-1:0]  cnt;
  logic           drain;

  logic [CW-1:0]  nb, base, cnt_nx;
  logic [W-1:0]   s_mask;
  logic [2*W-1:0] acc_nx;

  wire full_ok = (s_keep == '1);
  wire tail_ok = (s_keep != '0) && ((s_keep & (s_keep + 1'b1)) == '0);
  wire good    = s_last ? tail_ok : full_ok;
  wire pop     = m_valid && m_ready;
  wire push    = s_valid && s_ready;
  wire short_q = cnt < FULLC;

  assign m_valid = !short_q || (drain && cnt != '0);
  assign s_ready = !drain && (cnt <= FULLC || pop);
  assign m_data  = acc[W-1:0];
  assign base    = (pop && !short_q) ? cnt - FULLC : cnt;

  always_comb begin
    nb = '0;
    for (int i = 0; i < BYTES; i++) nb = nb + CW'(s_keep[i]);
    if (!good || !s_last) nb = FULLC;
    for (int i = 0; i < BYTES; i++)
      s_mask[8*i +: 8] = (CW'(i) < nb) ? s_data[8*i +: 8] : 8'h00;
  end

  always_comb begin
    acc_nx = acc;
    cnt_nx = cnt;
    if (pop) begin
      acc_nx = short_q ? '0 : (acc >> W);
      cnt_nx = short_q ? '0 : base;
    end
    if (push) begin
      acc_nx = acc_nx | ({{W{1'b0}}, s_mask} << {base, 3'b000});
      cnt_nx = base + nb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      cnt      <= '0;
      drain    <= 1'b0;
      keep_err <= 1'b0;
    end else begin
      acc      <= acc_nx;
      cnt      <= cnt_nx;
      drain    <= flush || (drain && cnt_nx != '0);
      keep_err <= push && !good;
    end
  end
endmodule

// File: rtl/byte_packer_chk.sv
module byte_packer_chk #(
  parameter int BYTES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s_valid,
  input logic               s_ready,
  input logic               m_valid,
  input logic               m_ready,
  input logic [8*BYTES-1:0] m_data,
  input logic               keep_err,
  input logic [$clog2(2*BYTES+1)-1:0] cnt,
  input logic               drain
);
  localparam int CW = $clog2(2*BYTES + 1);
  localparam logic [CW-1:0] FULLC = CW'(BYTES);
  localparam logic [CW-1:0] CAPC  = CW'(2*BYTES);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAPC);

  a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > FULLC) && !m_ready |-> !s_ready);

  a_r8_drain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> !s_ready);

  a_r9_partial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !drain && (cnt < FULLC) |-> !m_valid);

  a_r5_err_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    keep_err |-> $past(s_valid && s_ready));
endmodule

bind byte_packer byte_packer_chk #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .keep_err(keep_err), .cnt(cnt), .drain(drain)
);

// File: tb/test_byte_packer.sv
module test_byte_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0, flush = 1'b0;
  logic [31:0] s_data = '0;
  logic [3:0]  s_keep = '0;
  logic        s_ready, m_valid, keep_err;
  logic [31:0] m_data;

  int total = 0, bad = 0;
  logic [7:0] q[$];
  logic err_exp = 1'b0;

  always #2.5 clk = ~clk;

  byte_packer i_byte_packer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_keep(s_keep), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .flush(flush), .keep_err(keep_err)
  );

  // {err, last, keep, data}
  localparam int NV = 14;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'hF, 32'h03020100},
    {1'b0, 1'b1, 4'hF, 32'h07060504},
    {1'b0, 1'b1, 4'h1, 32'h0B0A0908},
    {1'b0, 1'b0, 4'hF, 32'h0F0E0D0C},
    {1'b0, 1'b1, 4'h3, 32'h13121110},
    {1'b0, 1'b1, 4'h7, 32'h17161514},
    {1'b1, 1'b1, 4'h5, 32'h1B1A1918},
    {1'b1, 1'b1, 4'h0, 32'h1F1E1D1C},
    {1'b1, 1'b0, 4'hB, 32'h23222120},
    {1'b0, 1'b1, 4'hF, 32'h27262524},
    {1'b0, 1'b1, 4'h1, 32'h2B2A2928},
    {1'b0, 1'b1, 4'h3, 32'h2F2E2D2C},
    {1'b1, 1'b1, 4'h8, 32'h33323130},
    {1'b1, 1'b1, 4'hE, 32'h37363534}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // R4/R5: bytes kept for a beat, counted from trailing ones of the mask
  function automatic int kept(input logic [3:0] k, input logic l);
    int t = 0;
    while (t < 4 && k[t]) t++;
    if (!l) return 4;
    if (t == 0 || t != $countones(k)) return 4;
    return t;
  endfunction

  function automatic bit mask_ok(input logic [3:0] k, input logic l);
    int t = 0;
    while (t < 4 && k[t]) t++;
    if (!l) return k == 4'hF;
    return t > 0 && t == $countones(k);
  endfunction

  task automatic step(input logic sv, input logic [31:0] d, input logic [3:0] k,
                      input logic l, input logic mr, input logic fl, output logic took);
    logic [31:0] e;
    int n;
    @(negedge clk);
    if (err_exp || keep_err) chk(keep_err == err_exp, "R5 keep_err", {31'b0, keep_err}, {31'b0, err_exp});
    s_valid = sv; s_data = d; s_keep = k; s_last = l; m_ready = mr; flush = fl;
    #1;
    took = sv && s_ready;
    if (m_valid && m_ready) begin
      e = '0;
      n = (q.size() < 4) ? q.size() : 4;
      for (int i = 0; i < n; i++) e[8*i +: 8] = q.pop_front();
      chk(n > 0 && m_data == e, "R2/R3 output bytes", m_data, e);
    end
    if (took) begin
      n = kept(k, l);
      for (int i = 0; i < n; i++) q.push_back(d[8*i +: 8]);
    end
    err_exp = took && !mask_ok(k, l);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic took;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!m_valid, "R1 m_valid after reset", {31'b0, m_valid}, 0);
    chk(s_ready, "R1 s_ready after reset", {31'b0, s_ready}, 1);
    chk(!keep_err, "R1 keep_err after reset", {31'b0, keep_err}, 0);

    // table walk: R2 R3 R4 R5 with intermittent output stalls
    for (int i = 0; i < NV; i++) begin
      int c = 0;
      chk(VEC[i][37] == !mask_ok(VEC[i][35:32], VEC[i][36]), "R4 table mask class", {31'b0, VEC[i][37]}, 0);
      do begin
        step(1'b1, VEC[i][31:0], VEC[i][35:32], VEC[i][36], (c % 3) != 2, 1'b0, took);
        c++;
      end while (!took);
    end
    repeat (4) step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, took);
    chk(q.size() == 1, "R9 one residual byte held", q.size(), 1);
    chk(!m_valid, "R9 no beat for a partial store", {31'b0, m_valid}, 0);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, took);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, took);
    chk(m_valid && !s_ready, "R8 flush beat offered, input blocked", {30'b0, m_valid, s_ready}, 32'h2);
    chk(m_data == 32'h00000037, "R8 zero padded flush beat", m_data, 32'h00000037);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, took);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, took);
    chk(q.size() == 0 && s_ready && !m_valid, "R8 drained and reopened", {30'b0, m_valid, s_ready}, 32'h1);

    // R9 then R8 with two bytes
    step(1'b1, 32'hDDCCBBAA, 4'h3, 1'b1, 1'b1, 1'b0, took);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, took);
    chk(!m_valid, "R9 two bytes held, no beat", {31'b0, m_valid}, 0);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, took);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, took);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, took);
    chk(q.size() == 0, "R8 two-byte flush consumed", q.size(), 0);

    // R6 R7 back-pressure
    step(1'b1, 32'hA3A2A1A0, 4'hF, 1'b0, 1'b0, 1'b0, took);
    chk(took, "R7 first stalled beat accepted", {31'b0, took}, 1);
    step(1'b1, 32'hB3B2B1B0, 4'hF, 1'b0, 1'b0, 1'b0, took);
    chk(took, "R7 second stalled beat accepted", {31'b0, took}, 1);
    step(1'b1, 32'hC3C2C1C0, 4'hF, 1'b1, 1'b0, 1'b0, took);
    chk(!took, "R7 full store refuses input", {31'b0, took}, 0);
    chk(m_valid && m_data == 32'hA3A2A1A0, "R6 held output", m_data, 32'hA3A2A1A0);
    step(1'b1, 32'hC3C2C1C0, 4'hF, 1'b1, 1'b0, 1'b0, took);
    chk(m_valid && m_data == 32'hA3A2A1A0, "R6 still held", m_data, 32'hA3A2A1A0);
    do step(1'b1, 32'hC3C2C1C0, 4'hF, 1'b1, 1'b1, 1'b0, took); while (!took);
    repeat (4) step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, took);
    chk(q.size() == 0, "R6 stalled data drained", q.size(), 0);

    // R10 throughput, R2 single register stage
    for (int i = 0; i < 6; i++) begin
      step(1'b1, {4{8'(8'h50 + i)}}, 4'hF, i == 5, 1'b1, 1'b0, took);
      chk(took, "R10 accepted every cycle", {31'b0, took}, 1);
      if (i > 0) chk(m_valid, "R2 beat out one stage later", {31'b0, m_valid}, 1);
    end
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, took);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, took);
    chk(q.size() == 0 && !m_valid, "R10 run fully delivered", q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule